// File: doc/BRIEF.md
# Split-Mode Integer ALU with Result Loopback

This block is a single-cycle integer execution unit on a 64-bit datapath. One control input picks its width: it works either as one 64-bit ALU or as two independent 32-bit ALUs, one on the low half and one on the high half. In split mode both halves compute in the same cycle and no carry passes from the low half to the high half.

Each cycle the unit can add, subtract, apply a bitwise AND, OR or XOR, shift logically by zero to three places, or pass the second operand through. A clock edge with the valid input high loads the result and the carry flags into output registers. The registered result also drives a loopback path into the first operand's selector. A dependent operation can therefore issue on the very next cycle without the result going back out through external operands.

Top module: `split_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the result and both carry flags are cleared to zero.
- R2: With `split_mode` low and opcode 0 (add), `{cout_hi, result}` equals the 65-bit sum of the two 64-bit operands, and `cout_lo` is 0. Outputs appear after the rising edge that samples the inputs.
- R3: With `split_mode` high and opcode 0, the low and high 32-bit halves are added independently. `cout_lo` is the carry out of bit 31, `cout_hi` is the carry out of bit 63, and no carry crosses from bit 31 into bit 32.
- R4: Opcode 1 (subtract) computes A + ~B + 1 on each active width: once over 64 bits in full mode, and separately per half in split mode. The carry flags follow the same rules as add, so a carry of 1 means no borrow.
- R5: Opcodes 2, 3 and 4 give A AND B, A OR B and A XOR B over all 64 bits. Both carry flags are 0.
- R6: Opcode 5 shifts A left and opcode 6 shifts A right, logically, by `shamt` (0 to 3), filling with zeros. In split mode each 32-bit half shifts on its own, so bits never move across the half boundary. Both carry flags are 0.
- R7: Opcode 7 passes B to the result, and both carry flags are 0.
- R8: When `lb_en` is high, operand A is the currently registered result and not `opnd_a`.
- R9: When `in_valid` is low, the result and both carry flags keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs valid; loads the result registers |
| op | input | 3 | Opcode (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shl, 6 shr, 7 pass B) |
| split_mode | input | 1 | 1 = two independent 32-bit ALUs, 0 = one 64-bit ALU |
| lb_en | input | 1 | Take operand A from the registered result |
| shamt | input | 2 | Shift distance for opcodes 5 and 6 |
| opnd_a | input | 64 | External operand A |
| opnd_b | input | 64 | External operand B |
| result | output | 64 | Registered result |
| cout_lo | output | 1 | Carry out of bit 31 (split mode add/sub only) |
| cout_hi | output | 1 | Carry out of bit 63 |

## Verification
The bench sets up carries that would ripple across bit 31. A unit that did not cut the chain in split mode would add one to the high half, and one that cut it in full mode would drop the carry into bit 32. Split subtraction with a borrow only in the low half tests that each half gets its own carry-in of one, since sharing a single carry-in corrupts the high half. Shifts of a pattern with bits 31 and 32 set test the half boundary, and wrong handling leaks a bit into the other half. Chains of loopback operations, with `opnd_a` set to garbage, and idle cycles with changing inputs test that a stale or external operand is never used and that the registers hold when no valid input arrives.

// File: rtl/split_alu_pkg.sv
// Shared opcode encoding for the split-mode ALU.
// Assumes a 3-bit opcode field; all eight codes are defined.
package split_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;
endpackage

// File: rtl/split_alu_shift.sv
// Logical shifter covering both widths: shifts the whole 2*HALF_W word, or each
// half independently when split is set. Zeros fill vacated positions.
// Assumes amt is small (a few bits); purely combinational.
module split_alu_shift #(
    parameter int HALF_W = 32,
    parameter int SH_W   = 2
) (
    input  logic [2*HALF_W-1:0] din,
    input  logic [SH_W-1:0]     amt,
    input  logic                left,
    input  logic                split,
    output logic [2*HALF_W-1:0] dout
);
    localparam int W = 2 * HALF_W;

    logic [W-1:0] full_sh;
    logic [W-1:0] part_sh;

    // Full-width shift
    assign full_sh = left ? (din << amt) : (din >> amt);

    // Per-half shifts, one per half
    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [HALF_W-1:0] slice;
        assign slice = din[g*HALF_W +: HALF_W];
        assign part_sh[g*HALF_W +: HALF_W] = left ? (slice << amt) : (slice >> amt);
    end

    // Width select
    assign dout = split ? part_sh : full_sh;
endmodule

// File: rtl/split_alu_addseg.sv
// One half-width adder segment with explicit carry-in and carry-out.
// Assumes the caller handles operand inversion for subtraction.
module split_alu_addseg #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] wide;

    // Behavioural sum with carry
    assign wide = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    assign sum  = wide[WIDTH-1:0];
    assign cout = wide[WIDTH];
endmodule

// File: rtl/split_alu.sv
// Single-cycle integer ALU, one 2*HALF_W unit or two HALF_W units (split_mode).
// Operand A comes from opnd_a or from the registered result (lb_en). Operand B is
// inverted for subtraction. The output mux picks sum, logic, shift or pass.
// Assumes synchronous active-low reset; registers load only when in_valid.
module split_alu
    import split_alu_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int SH_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic                split_mode,
    input  logic                lb_en,
    input  logic [SH_W-1:0]     shamt,
    input  logic [2*HALF_W-1:0] opnd_a,
    input  logic [2*HALF_W-1:0] opnd_b,
    output logic [2*HALF_W-1:0] result,
    output logic                cout_lo,
    output logic                cout_hi
);
    localparam int W = 2 * HALF_W;

    alu_op_e      op_e;
    logic [W-1:0] res_q;
    logic         clo_q, chi_q;
    logic [W-1:0] opa, opb_eff, sum, shifted, nxt_res;
    logic         is_sub, nxt_clo, nxt_chi;
    logic [1:0]   seg_cin, seg_cout;

    assign op_e = alu_op_e'(op);

    // Operand A select: external or loopback
    assign opa = lb_en ? res_q : opnd_a;

    // Sign control on operand B
    assign is_sub  = (op_e == OP_SUB);
    assign opb_eff = is_sub ? ~opnd_b : opnd_b;

    // Carry-in per segment; upper takes lower carry only in full mode
    assign seg_cin[0] = is_sub;
    assign seg_cin[1] = split_mode ? is_sub : seg_cout[0];

    // Adder segments
    for (genvar g = 0; g < 2; g++) begin : g_seg
        split_alu_addseg #(.WIDTH(HALF_W)) seg_i (
            .a    (opa[g*HALF_W +: HALF_W]),
            .b    (opb_eff[g*HALF_W +: HALF_W]),
            .cin  (seg_cin[g]),
            .sum  (sum[g*HALF_W +: HALF_W]),
            .cout (seg_cout[g])
        );
    end

    // Shifter
    split_alu_shift #(.HALF_W(HALF_W), .SH_W(SH_W)) shift_i (
        .din   (opa),
        .amt   (shamt),
        .left  (op_e == OP_SHL),
        .split (split_mode),
        .dout  (shifted)
    );

    // Output mux and carry selection
    always_comb begin
        nxt_clo = 1'b0;
        nxt_chi = 1'b0;
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                nxt_res = sum;
                nxt_clo = split_mode & seg_cout[0];
                nxt_chi = seg_cout[1];
            end
            OP_AND:         nxt_res = opa & opnd_b;
            OP_OR:          nxt_res = opa | opnd_b;
            OP_XOR:         nxt_res = opa ^ opnd_b;
            OP_SHL, OP_SHR: nxt_res = shifted;
            default:        nxt_res = opnd_b;
        endcase
    end

    // Result and carry registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            clo_q <= 1'b0;
            chi_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= nxt_res;
            clo_q <= nxt_clo;
            chi_q <= nxt_chi;
        end
    end

    assign result  = res_q;
    assign cout_lo = clo_q;
    assign cout_hi = chi_q;
endmodule

// File: rtl/split_alu_chk.sv
// Property checker for split_alu, attached by bind. Observes ports only.
// Assumes the opcode encoding of split_alu_pkg.
module split_alu_chk
    import split_alu_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int SH_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2:0]          op,
    input logic                split_mode,
    input logic                lb_en,
    input logic [SH_W-1:0]     shamt,
    input logic [2*HALF_W-1:0] opnd_a,
    input logic [2*HALF_W-1:0] opnd_b,
    input logic [2*HALF_W-1:0] result,
    input logic                cout_lo,
    input logic                cout_hi
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !cout_lo && !cout_hi));

    p_full_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !split_mode && !lb_en && op == OP_ADD)
        |=> {cout_hi, result} == ($past({1'b0, opnd_a}) + $past({1'b0, opnd_b})));

    p_full_no_lo_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !split_mode) |=> !cout_lo);

    p_split_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && split_mode && !lb_en && op == OP_ADD)
        |=> {cout_hi, result[2*HALF_W-1:HALF_W]} ==
            ($past({1'b0, opnd_a[2*HALF_W-1:HALF_W]}) + $past({1'b0, opnd_b[2*HALF_W-1:HALF_W]})));

    p_logic_no_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR))
        |=> (!cout_lo && !cout_hi));

    p_loopback_xor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lb_en && op == OP_XOR)
        |=> result == ($past(result) ^ $past(opnd_b)));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(cout_lo) && $stable(cout_hi)));
endmodule

bind split_alu split_alu_chk #(.HALF_W(HALF_W), .SH_W(SH_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .split_mode(split_mode), .lb_en(lb_en), .shamt(shamt),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .cout_lo(cout_lo), .cout_hi(cout_hi)
);

// File: tb/split_alu_tb_top.sv
`timescale 1ns/1ps
module split_alu_tb_top;
    localparam logic [2:0] C_ADD = 3'd0, C_SUB = 3'd1, C_AND = 3'd2, C_OR = 3'd3,
                           C_XOR = 3'd4, C_SHL = 3'd5, C_SHR = 3'd6, C_PASS = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        split_mode = 1'b0;
    logic        lb_en = 1'b0;
    logic [1:0]  shamt = 2'd0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [63:0] result;
    logic        cout_lo, cout_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [65:0] model_q = '0;   // {cout_hi, cout_lo, result}

    always #2 clk = ~clk;

    split_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .split_mode(split_mode), .lb_en(lb_en), .shamt(shamt),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .cout_lo(cout_lo), .cout_hi(cout_hi)
    );

    // Expected {cout_hi, cout_lo, result} from the requirements
    function automatic logic [65:0] expect_of(input logic [2:0] f, input logic sp,
                                              input logic [1:0] s, input logic [63:0] a,
                                              input logic [63:0] b);
        logic [63:0] bb;
        logic [32:0] lo, hi;
        logic [64:0] w;
        logic        ci;
        case (f)
            C_ADD, C_SUB: begin
                ci = (f == C_SUB);
                bb = ci ? ~b : b;
                if (sp) begin
                    lo = {1'b0, a[31:0]}  + {1'b0, bb[31:0]}  + 33'(ci);
                    hi = {1'b0, a[63:32]} + {1'b0, bb[63:32]} + 33'(ci);
                    return {hi[32], lo[32], hi[31:0], lo[31:0]};
                end
                w = {1'b0, a} + {1'b0, bb} + 65'(ci);
                return {w[64], 1'b0, w[63:0]};
            end
            C_AND: return {2'b00, a & b};
            C_OR:  return {2'b00, a | b};
            C_XOR: return {2'b00, a ^ b};
            C_SHL: return sp ? {2'b00, a[63:32] << s, a[31:0] << s} : {2'b00, a << s};
            C_SHR: return sp ? {2'b00, a[63:32] >> s, a[31:0] >> s} : {2'b00, a >> s};
            default: return {2'b00, b};
        endcase
    endfunction

    task automatic compare(input string tag);
        n_checks++;
        if ({cout_hi, cout_lo, result} !== model_q) begin
            n_fail++;
            $display("FAIL %s: got co_hi=%b co_lo=%b res=%h, expected co_hi=%b co_lo=%b res=%h",
                     tag, cout_hi, cout_lo, result, model_q[65], model_q[64], model_q[63:0]);
        end
    endtask

    // One valid operation, checked after the capturing edge
    task automatic apply(input string tag, input logic [2:0] f, input logic sp,
                         input logic lb, input logic [1:0] s,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op = f; split_mode = sp; lb_en = lb; shamt = s;
        opnd_a = a; opnd_b = b;
        model_q = expect_of(f, sp, s, lb ? model_q[63:0] : a, b);
        @(negedge clk);
        in_valid = 1'b0;
        compare(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_q = '0;
        @(negedge clk);
        compare("R1 power-up reset");
        rst_n = 1'b1;
        apply("R2 setup before reset", C_ADD, 1'b0, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; op = C_PASS; opnd_b = 64'hDEAD;
        model_q = '0;
        @(negedge clk);
        compare("R1 reset overrides valid");
        rst_n = 1'b1; in_valid = 1'b0;
    endtask

    task automatic t_full_add();
        apply("R2 carry across bit 31", C_ADD, 1'b0, 1'b0, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'd1);
        apply("R2 carry out of bit 63", C_ADD, 1'b0, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        apply("R2 mixed operands",      C_ADD, 1'b0, 1'b0, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
    endtask

    task automatic t_split_add();
        apply("R3 low carry cut",  C_ADD, 1'b1, 1'b0, 2'd0, 64'h0000_0007_FFFF_FFFF, 64'h0000_0001_0000_0001);
        apply("R3 both carries",   C_ADD, 1'b1, 1'b0, 2'd0, 64'hFFFF_FFFF_8000_0000, 64'h0000_0002_8000_0000);
        apply("R3 high only",      C_ADD, 1'b1, 1'b0, 2'd0, 64'hF000_0000_0000_0010, 64'h1000_0000_0000_0020);
    endtask

    task automatic t_sub();
        apply("R4 full sub borrow", C_SUB, 1'b0, 1'b0, 2'd0, 64'd5, 64'd7);
        apply("R4 full sub equal",  C_SUB, 1'b0, 1'b0, 2'd0, 64'h1_0000_0000, 64'h1_0000_0000);
        apply("R4 split low borrow", C_SUB, 1'b1, 1'b0, 2'd0, 64'h0000_0009_0000_0000, 64'h0000_0004_0000_0001);
        apply("R4 split high borrow", C_SUB, 1'b1, 1'b0, 2'd0, 64'h0000_0001_0000_0003, 64'h0000_0002_0000_0003);
    endtask

    task automatic t_logic();
        apply("R5 and", C_AND, 1'b0, 1'b0, 2'd0, 64'hF0F0_FFFF_0000_AAAA, 64'hFF00_0F0F_FFFF_5555);
        apply("R5 or",  C_OR,  1'b1, 1'b0, 2'd0, 64'hF0F0_0000_1234_0000, 64'h0F0F_0000_0000_5678);
        apply("R5 xor", C_XOR, 1'b0, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_shift();
        apply("R6 split shl boundary", C_SHL, 1'b1, 1'b0, 2'd3, 64'h8000_0001_F000_0001, 64'd0);
        apply("R6 full shl boundary",  C_SHL, 1'b0, 1'b0, 2'd3, 64'h8000_0001_F000_0001, 64'd0);
        apply("R6 split shr boundary", C_SHR, 1'b1, 1'b0, 2'd2, 64'h0000_0003_8000_0001, 64'd0);
        apply("R6 full shr boundary",  C_SHR, 1'b0, 1'b0, 2'd2, 64'h0000_0003_8000_0001, 64'd0);
        apply("R6 shift by zero",      C_SHL, 1'b1, 1'b0, 2'd0, 64'hCAFE_0000_BEEF_0001, 64'd0);
    endtask

    task automatic t_pass();
        apply("R7 pass B", C_PASS, 1'b1, 1'b0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0BAD_F00D_1234_5678);
    endtask

    task automatic t_loopback();
        apply("R8 seed",            C_ADD, 1'b0, 1'b0, 2'd0, 64'h0000_0000_FFFF_FFF0, 64'd8);
        apply("R8 dependent add",   C_ADD, 1'b0, 1'b1, 2'd0, 64'hAAAA_AAAA_AAAA_AAAA, 64'd8);
        apply("R8 dependent shl",   C_SHL, 1'b1, 1'b1, 2'd1, 64'h5555_5555_5555_5555, 64'd0);
        apply("R8 dependent xor",   C_XOR, 1'b0, 1'b1, 2'd0, 64'd0, 64'h00FF_00FF_00FF_00FF);
        apply("R8 dependent sub",   C_SUB, 1'b1, 1'b1, 2'd0, 64'h1234, 64'h0000_0001_0000_0001);
    endtask

    task automatic t_hold();
        apply("R9 seed", C_SUB, 1'b0, 1'b0, 2'd0, 64'd3, 64'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b0; op = 3'(k + 2); split_mode = k[0]; lb_en = 1'b1;
            opnd_a = {32'hFFFF_FFFF, 32'(k)}; opnd_b = 64'h1111_1111 * (k + 1);
            @(negedge clk);
            compare("R9 idle hold");
        end
    endtask

    initial begin
        t_reset();
        t_full_add();
        t_split_add();
        t_sub();
        t_logic();
        t_shift();
        t_pass();
        t_loopback();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule